// File: doc/BRIEF.md
# Serial Link Rate Divider Planner

This block turns a requested serial lane bit rate, given in hertz, into the settings a transmit clock generator needs. The rate is first limited to a legal window. The limited rate then selects a power-of-two transmit divider and a pair of 2-bit divider field codes. From the limited rate and the chosen divider, the block computes a 31-bit fixed-point control word for the loop, measured against a fixed 26 MHz reference. The word has 7 integer bits and 24 fraction bits.

A request is a one-cycle `start_i` pulse that carries `rate_i`. The block answers with a one-cycle `done_o` pulse. The control word comes from a sequential restoring divider that resolves one quotient bit per clock. While that divider runs, `busy_o` is high and any new request is dropped. A request in an illegal band is rejected in a single cycle with `err_o`. The result registers keep the last answer until the next answer replaces it.

Top module: `rate_div_planner`

## Requirements
- R1: Rates above 1,250,000,000 are treated as exactly 1,250,000,000. When `CLAMP_LOW`=1, rates below 50,000,000 are treated as exactly 50,000,000.
- R2: A limited rate of 500,000,000 or more gives `txdiv_o`=1, `code0_o`=0 and `code1_o`=0.
- R3: A limited rate from 250,000,000 up to 499,999,999 gives `txdiv_o`=2, `code0_o`=1 and `code1_o`=0.
- R4: A limited rate from 125,000,000 up to 249,999,999 gives `txdiv_o`=4, `code0_o`=2 and `code1_o`=0.
- R5: A limited rate strictly above 62,000,000 and below 125,000,000 gives `txdiv_o`=8, `code0_o`=2 and `code1_o`=1. A rate of exactly 62,000,000 is not in this band.
- R6: A limited rate from 50,000,000 up to 62,000,000 inclusive gives `txdiv_o`=16, `code0_o`=2 and `code1_o`=2.
- R7: With `CLAMP_LOW`=0, a rate below 50,000,000 gives a `done_o` pulse in the cycle after the start cycle. That answer has `err_o`=1 and `pcw_o`, `txdiv_o`, `code0_o` and `code1_o` all at 0. A valid answer has `err_o`=0.
- R8: `pcw_o` = floor(limited_rate × 2 × `txdiv_o` × 2^24 / 26,000,000). Bits 30:24 hold the integer part and bits 23:0 hold the fraction.
- R9: For a valid request, `done_o` is a one-cycle pulse seen 64 clock edges after the edge that accepts `start_i`. `busy_o` stays high from the accepting edge until the answer appears.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The pending answer belongs to the first request, and only one `done_o` pulse appears.
- R11: All result outputs hold their values after `done_o` until the next answer is produced.
- R12: After reset, `done_o`, `busy_o`, `err_o`, `txdiv_o`, `code0_o`, `code1_o` and `pcw_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, one cycle |
| rate_i | input | 32 | Requested bit rate in hertz |
| busy_o | output | 1 | Division in progress; requests are ignored |
| done_o | output | 1 | One-cycle answer strobe |
| err_o | output | 1 | Last answer was a rejected rate |
| txdiv_o | output | 5 | Transmit divider value (1, 2, 4, 8, 16) |
| code0_o | output | 2 | First divider field code |
| code1_o | output | 2 | Second divider field code |
| pcw_o | output | 31 | Fixed-point loop control word (7.24) |

## Verification
The bench builds two copies of the block with one shared stimulus. One copy uses the default `CLAMP_LOW`=1, and there sub-range rates are lifted into the 16× band. The other uses `CLAMP_LOW`=0, which is the only setting that makes the single-cycle rejection path reachable. The other parameters stay at their defaults: 32-bit rate, 24 fraction bits, 64-bit dividend and 26 MHz reference. With those values the 64-cycle latency is measured and the exact truncated control word is compared at every band edge, including the strict 62 MHz boundary.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    // Band edges in hertz; the comparison kind of each edge is part of behaviour.
    localparam logic [31:0] EDGE_X1_HZ  = 32'd500_000_000;   // >=
    localparam logic [31:0] EDGE_X2_HZ  = 32'd250_000_000;   // >=
    localparam logic [31:0] EDGE_X4_HZ  = 32'd125_000_000;   // >=
    localparam logic [31:0] EDGE_X8_HZ  = 32'd62_000_000;    // >  (strict)

    typedef struct packed {
        logic       err;
        logic [2:0] lg;     // log2 of transmit divider
        logic [1:0] c0;
        logic [1:0] c1;
    } band_t;

endpackage

// File: rtl/rdp_band_sel.sv
module rdp_band_sel
    import rdp_pkg::*;
#(
    parameter int                RATE_W    = 32,
    parameter logic [RATE_W-1:0] MIN_HZ    = RATE_W'(50_000_000),
    parameter logic [RATE_W-1:0] MAX_HZ    = RATE_W'(1_250_000_000),
    parameter bit                CLAMP_LOW = 1'b1
) (
    input  logic [RATE_W-1:0] rate_i,
    output logic [RATE_W-1:0] rate_c_o,
    output band_t             band_o
);

    logic [RATE_W-1:0] hi_lim;

    always_comb begin
        hi_lim = (rate_i > MAX_HZ) ? MAX_HZ : rate_i;
        if (CLAMP_LOW && (hi_lim < MIN_HZ)) begin
            rate_c_o = MIN_HZ;
        end else begin
            rate_c_o = hi_lim;
        end
    end

    always_comb begin
        band_o = '0;
        if (rate_c_o >= RATE_W'(EDGE_X1_HZ)) begin
            band_o.lg = 3'd0; band_o.c0 = 2'd0; band_o.c1 = 2'd0;
        end else if (rate_c_o >= RATE_W'(EDGE_X2_HZ)) begin
            band_o.lg = 3'd1; band_o.c0 = 2'd1; band_o.c1 = 2'd0;
        end else if (rate_c_o >= RATE_W'(EDGE_X4_HZ)) begin
            band_o.lg = 3'd2; band_o.c0 = 2'd2; band_o.c1 = 2'd0;
        end else if (rate_c_o > RATE_W'(EDGE_X8_HZ)) begin
            band_o.lg = 3'd3; band_o.c0 = 2'd2; band_o.c1 = 2'd1;
        end else if (rate_c_o >= MIN_HZ) begin
            band_o.lg = 3'd4; band_o.c0 = 2'd2; band_o.c1 = 2'd2;
        end else begin
            band_o.err = 1'b1;
        end
    end

endmodule

// File: rtl/rdp_seq_div.sv
module rdp_seq_div #(
    parameter int DVD_W = 64,
    parameter int DVS_W = 32,
    parameter int QO_W  = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic             done_o,
    output logic [QO_W-1:0]  quot_o
);

    localparam int CNT_W = $clog2(DVD_W);

    typedef struct packed {
        logic [DVS_W:0]   rem;
        logic [DVD_W-1:0] dq;    // dividend shifts out, quotient shifts in
    } step_t;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        step_t            s;
    } st_t;

    st_t q, d;

    function automatic step_t div_step(input step_t cur, input logic [DVS_W-1:0] dvs);
        step_t          nx;
        logic [DVS_W:0] sh;
        sh = {cur.rem[DVS_W-1:0], cur.dq[DVD_W-1]};
        if (sh >= {1'b0, dvs}) begin
            nx.rem = sh - {1'b0, dvs};
            nx.dq  = {cur.dq[DVD_W-2:0], 1'b1};
        end else begin
            nx.rem = sh;
            nx.dq  = {cur.dq[DVD_W-2:0], 1'b0};
        end
        return nx;
    endfunction

    always_comb begin
        step_t ld;
        d      = q;
        d.done = 1'b0;
        ld.rem = '0;
        ld.dq  = dividend_i;
        if (!q.busy && start_i) begin
            d.s    = div_step(ld, divisor_i);
            d.busy = 1'b1;
            d.cnt  = CNT_W'(1);
        end else if (q.busy) begin
            d.s   = div_step(q.s, divisor_i);
            d.cnt = q.cnt + CNT_W'(1);
            if (q.cnt == CNT_W'(DVD_W - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign quot_o = q.s.dq[QO_W-1:0];

endmodule

// File: rtl/rate_div_planner.sv
module rate_div_planner
    import rdp_pkg::*;
#(
    parameter int                RATE_W    = 32,
    parameter logic [RATE_W-1:0] MIN_HZ    = RATE_W'(50_000_000),
    parameter logic [RATE_W-1:0] MAX_HZ    = RATE_W'(1_250_000_000),
    parameter logic [RATE_W-1:0] REF_HZ    = RATE_W'(26_000_000),
    parameter int                FRAC_W    = 24,
    parameter int                DVD_W     = 64,
    parameter int                PCW_W     = 31,
    parameter bit                CLAMP_LOW = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [4:0]        txdiv_o,
    output logic [1:0]        code0_o,
    output logic [1:0]        code1_o,
    output logic [PCW_W-1:0]  pcw_o
);

    localparam int TXD_W  = 5;
    localparam int PROD_W = RATE_W + TXD_W;

    typedef struct packed {
        logic             busy;
        logic [2:0]       p_lg;
        logic [1:0]       p_c0;
        logic [1:0]       p_c1;
        logic             done;
        logic             err;
        logic [TXD_W-1:0] txdiv;
        logic [1:0]       c0;
        logic [1:0]       c1;
        logic [PCW_W-1:0] pcw;
    } st_t;

    st_t q, d;

    logic [RATE_W-1:0] rate_c;
    band_t             band;
    logic [PROD_W-1:0] prod;
    logic [DVD_W-1:0]  dvd;
    logic              div_go;
    logic              div_done;
    logic [PCW_W-1:0]  quot;

    rdp_band_sel #(
        .RATE_W(RATE_W), .MIN_HZ(MIN_HZ), .MAX_HZ(MAX_HZ), .CLAMP_LOW(CLAMP_LOW)
    ) u_band (
        .rate_i  (rate_i),
        .rate_c_o(rate_c),
        .band_o  (band)
    );

    always_comb begin
        prod   = PROD_W'(rate_c) << (band.lg + 3'd1);
        dvd    = DVD_W'(prod) << FRAC_W;
        div_go = start_i && !q.busy && !band.err;
    end

    rdp_seq_div #(
        .DVD_W(DVD_W), .DVS_W(RATE_W), .QO_W(PCW_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (div_go),
        .dividend_i(dvd),
        .divisor_i (REF_HZ),
        .done_o    (div_done),
        .quot_o    (quot)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy && start_i) begin
            if (band.err) begin
                d.done  = 1'b1;
                d.err   = 1'b1;
                d.txdiv = '0;
                d.c0    = '0;
                d.c1    = '0;
                d.pcw   = '0;
            end else begin
                d.busy = 1'b1;
                d.p_lg = band.lg;
                d.p_c0 = band.c0;
                d.p_c1 = band.c1;
            end
        end else if (q.busy && div_done) begin
            d.busy  = 1'b0;
            d.done  = 1'b1;
            d.err   = 1'b0;
            d.txdiv = TXD_W'(1) << q.p_lg;
            d.c0    = q.p_c0;
            d.c1    = q.p_c1;
            d.pcw   = quot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o  = q.busy;
    assign done_o  = q.done;
    assign err_o   = q.err;
    assign txdiv_o = q.txdiv;
    assign code0_o = q.c0;
    assign code1_o = q.c1;
    assign pcw_o   = q.pcw;

endmodule

// File: rtl/rdp_checker.sv
module rdp_checker #(
    parameter int PCW_W = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o,
    input logic [4:0]       txdiv_o,
    input logic [1:0]       code0_o,
    input logic [1:0]       code1_o,
    input logic [PCW_W-1:0] pcw_o
);

    // R2..R6: every valid answer carries one of the five legal divider/code pairings
    a_r2_legal_pairing: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |->
            ((txdiv_o == 5'd1  && code0_o == 2'd0 && code1_o == 2'd0) ||
             (txdiv_o == 5'd2  && code0_o == 2'd1 && code1_o == 2'd0) ||
             (txdiv_o == 5'd4  && code0_o == 2'd2 && code1_o == 2'd0) ||
             (txdiv_o == 5'd8  && code0_o == 2'd2 && code1_o == 2'd1) ||
             (txdiv_o == 5'd16 && code0_o == 2'd2 && code1_o == 2'd2)));

    // R7: a rejected answer carries no result
    a_r7_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (pcw_o == '0 && txdiv_o == 5'd0 && code0_o == 2'd0 && code1_o == 2'd0));

    // R9: done is a single-cycle strobe
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9/R10: busy ends only with an answer, regardless of extra starts
    a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

    // R11: results change only when an answer appears
    a_r11_hold_pcw: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(pcw_o) && $stable(txdiv_o) && $stable(err_o)));

endmodule

bind rate_div_planner rdp_checker #(.PCW_W(PCW_W)) u_rdp_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .err_o  (err_o),
    .txdiv_o(txdiv_o),
    .code0_o(code0_o),
    .code1_o(code1_o),
    .pcw_o  (pcw_o)
);

// File: tb/tb_rate_div_planner.sv
module tb_rate_div_planner;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] rate_i = '0;

    logic        busy_a, done_a, err_a, busy_b, done_b, err_b;
    logic [4:0]  txd_a, txd_b;
    logic [1:0]  c0_a, c1_a, c0_b, c1_b;
    logic [30:0] pcw_a, pcw_b;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rate_div_planner dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rate_i(rate_i),
        .busy_o(busy_a), .done_o(done_a), .err_o(err_a), .txdiv_o(txd_a),
        .code0_o(c0_a), .code1_o(c1_a), .pcw_o(pcw_a)
    );

    rate_div_planner #(.CLAMP_LOW(1'b0)) dut_nc (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rate_i(rate_i),
        .busy_o(busy_b), .done_o(done_b), .err_o(err_b), .txdiv_o(txd_b),
        .code0_o(c0_b), .code1_o(c1_b), .pcw_o(pcw_b)
    );

    task automatic chk(input string tag, input string what,
                       input longint unsigned got, input longint unsigned exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Reference model written from the requirements
    task automatic model(input longint unsigned r_in, input bit cl,
                         output bit err, output int lg, output int c0, output int c1,
                         output longint unsigned pcw);
        longint unsigned r;
        r = (r_in > 64'd1250000000) ? 64'd1250000000 : r_in;
        if (cl && r < 64'd50000000) r = 64'd50000000;
        err = 1'b0; lg = 0; c0 = 0; c1 = 0;
        if (r >= 64'd500000000)      begin lg = 0; c0 = 0; c1 = 0; end
        else if (r >= 64'd250000000) begin lg = 1; c0 = 1; c1 = 0; end
        else if (r >= 64'd125000000) begin lg = 2; c0 = 2; c1 = 0; end
        else if (r > 64'd62000000)   begin lg = 3; c0 = 2; c1 = 1; end
        else if (r >= 64'd50000000)  begin lg = 4; c0 = 2; c1 = 2; end
        else err = 1'b1;
        pcw = err ? 64'd0 : (((r * 2 * (64'd1 << lg)) << 24) / 64'd26000000);
    endtask

    function automatic string band_tag(input int lg, input bit err);
        if (err) return "R7";
        case (lg)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check_one(input string who, input longint unsigned r, input bit cl,
                             input int k_done, input int n_done,
                             input bit e, input logic [4:0] t, input logic [1:0] a0,
                             input logic [1:0] a1, input logic [30:0] p);
        bit ee; int lg, x0, x1; longint unsigned xp; string bt, pt;
        model(r, cl, ee, lg, x0, x1, xp);
        bt = band_tag(lg, ee);
        pt = (r > 64'd1250000000 || r < 64'd50000000) ? "R1" : "R8";
        chk(ee ? "R7" : "R9", {who, " done count"}, n_done, 1);
        chk(ee ? "R7" : "R9", {who, " latency"}, k_done, ee ? 0 : 64);
        chk("R7", {who, " err"}, e, ee);
        chk(bt, {who, " txdiv"}, t, ee ? 0 : (1 << lg));
        chk(bt, {who, " code0"}, a0, x0);
        chk(bt, {who, " code1"}, a1, x1);
        chk(pt, {who, " pcw"}, p, xp);
    endtask

    task automatic run_req(input logic [31:0] r, input bit overlap, input logic [31:0] r2);
        int ka = -1, kb = -1, na = 0, nb = 0;
        bit ea = 0, eb = 0;
        logic [4:0] ta = '0, tb = '0;
        logic [1:0] a0 = '0, a1 = '0, b0 = '0, b1 = '0;
        logic [30:0] pa = '0, pb = '0;
        @(negedge clk);
        rate_i = r; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k <= 80; k++) begin
            if (done_a) begin na++; ka = k; ea = err_a; ta = txd_a; a0 = c0_a; a1 = c1_a; pa = pcw_a; end
            if (done_b) begin nb++; kb = k; eb = err_b; tb = txd_b; b0 = c0_b; b1 = c1_b; pb = pcw_b; end
            if (overlap && k == 5) chk("R10", "busy during division", busy_a, 1);
            if (overlap && k == 10) begin start_i = 1'b1; rate_i = r2; end
            if (k == 11) start_i = 1'b0;
            @(negedge clk);
        end
        check_one("clampA", {32'd0, r}, 1'b1, ka, na, ea, ta, a0, a1, pa);
        check_one("openB",  {32'd0, r}, 1'b0, kb, nb, eb, tb, b0, b1, pb);
        // R11: results still hold long after the answer
        chk("R11", "hold pcw", pcw_a, pa);
        chk("R11", "hold txdiv", txd_a, ta);
        chk("R11", "hold err B", err_b, eb);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12", "done", done_a, 0);
        chk("R12", "busy", busy_a, 0);
        chk("R12", "err", err_b, 0);
        chk("R12", "txdiv", txd_a, 0);
        chk("R12", "codes", {c0_a, c1_a}, 0);
        chk("R12", "pcw", pcw_a, 0);

        // Directed band edges, clamp edges and the strict 62 MHz edge
        run_req(32'd0, 0, 0);
        run_req(32'd49_999_999, 0, 0);
        run_req(32'd50_000_000, 0, 0);
        run_req(32'd62_000_000, 0, 0);
        run_req(32'd62_000_001, 0, 0);
        run_req(32'd124_999_999, 0, 0);
        run_req(32'd125_000_000, 0, 0);
        run_req(32'd249_999_999, 0, 0);
        run_req(32'd250_000_000, 0, 0);
        run_req(32'd499_999_999, 0, 0);
        run_req(32'd500_000_000, 0, 0);
        run_req(32'd1_250_000_000, 0, 0);
        run_req(32'd1_250_000_001, 0, 0);
        run_req(32'hFFFF_FFFF, 0, 0);
        // R10: second start during division is dropped
        run_req(32'd300_000_000, 1, 32'd80_000_000);
        run_req(32'd55_000_000, 1, 32'd1_000_000_000);

        for (int i = 0; i < 40; i++) begin
            logic [31:0] r;
            if (i % 4 == 0) r = $urandom;
            else            r = $urandom_range(1_300_000_000, 40_000_000);
            run_req(r, (i % 5 == 2) && (r >= 32'd50_000_000), $urandom);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule